// File: doc/BRIEF.md
# Composite Sync Generator with Command Override

This block produces horizontal, vertical and composite sync flags, plus a blanking flag, for a video pipeline fed by an upstream display controller. The controller presents a three-bit command code once per machine cycle. A clock enable marks the one pixel-clock cycle in eight in which that code is valid. A free-running line counter, stepped once per sampling slot, makes the horizontal sync pulses without any help from the controller. When the controller starts an explicit horizontal sync command, the counter is reloaded so that the internal pulse begins at once.

A horizontal sync command that lasts longer than one slot re-aligns the counter only in its first slot. After that slot the counter keeps its normal line period. The controller uses this during the vertical off-screen period: it sends a long horizontal sync command, holds vertical sync for three scanlines, then sends a long horizontal sync command again. Composite sync is the exclusive OR of the two flags. While vertical sync is held, each internal horizontal pulse therefore shows up in composite sync as a short return to blanking level, not as one solid pulse.

Top module: `csync_gen`

## Requirements
- R1: At every clock, `csync` equals `hsync` XOR `vsync`.
- R2: If no horizontal sync command arrives, `hsync` is high for HS_WIDTH slots (default 8) in every line of LINE_SLOTS slots (default 114). The pulse starts when the line position reaches HS_START (default 4).
- R3: A slot that samples code 3'b001 drives `vsync` high from that clock edge on. `vsync` stays high until a later slot samples a different code.
- R4: If a slot samples code 3'b010 and the previous slot sampled any other code, the line position is set to HS_START, so `hsync` rises at that edge. Further consecutive slots with 3'b010 do not re-align the counter, and the pulses continue at line timing.
- R5: Codes with bit 2 set are display data. They assert no vertical sync, cause no re-alignment, and leave `blank` low unless a sync flag is high.
- R6: While `rst_n` is low, `hsync`, `vsync` and `csync` are low and `blank` is high. After release, the line position starts from zero, so the first pulse begins HS_START slots later.
- R7: `blank` is high whenever `hsync` or `vsync` is high, or when the last sampled code had bit 2 clear.
- R8: The code is sampled only on clocks where `slot_en` is high. Outputs do not change on any other clock, whatever `cmd` carries then.
- R9: During a 3-line vertical sync held inside a long horizontal sync sequence, exactly 3 horizontal pulses appear, and `csync` drops low during each of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | High for one clock per machine cycle; command sampling slot |
| cmd | input | 3 | Display command code from the controller |
| hsync | output | 1 | Horizontal sync flag |
| vsync | output | 1 | Vertical sync flag |
| csync | output | 1 | Composite sync, hsync XOR vsync |
| blank | output | 1 | Blanking flag |

## Verification
Every result of a sampling slot is registered on the same clock edge that samples the code. `hsync`, `vsync`, `blank` and `csync` therefore take their new values one edge after the slot. They then hold for the seven clocks that follow, until the next slot.

The bench drives `cmd` and `slot_en` on falling edges. Its reference model updates on rising edges, and the bench compares the outputs with the model on every falling edge, half a period after the edge that moved them. Junk codes are placed on the non-slot clocks, so any sampling outside the slot shows up as a mismatch at the next falling edge.

// File: rtl/csync_gen.sv
module csync_gen #(
  parameter int LINE_SLOTS = 114,
  parameter int HS_START   = 4,
  parameter int HS_WIDTH   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot_en,
  input  logic [2:0] cmd,
  output logic       hsync,
  output logic       vsync,
  output logic       csync,
  output logic       blank
);
  localparam int CW = $clog2(LINE_SLOTS);
  localparam int HS_END = HS_START + HS_WIDTH;
  localparam logic [2:0] CODE_VS = 3'b001;
  localparam logic [2:0] CODE_HS = 3'b010;

  logic [CW-1:0] lpos;
  logic          hs_prev;
  logic          disp;
  logic          hs_code;

  assign hs_code = (cmd == CODE_HS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lpos    <= '0;
      vsync   <= 1'b0;
      hs_prev <= 1'b0;
      disp    <= 1'b0;
    end else if (slot_en) begin
      if (hs_code && !hs_prev)
        lpos <= CW'(HS_START);
      else if (lpos == CW'(LINE_SLOTS - 1))
        lpos <= '0;
      else
        lpos <= lpos + CW'(1);
      vsync   <= (cmd == CODE_VS);
      hs_prev <= hs_code;
      disp    <= cmd[2];
    end
  end

  assign hsync = (int'(lpos) >= HS_START) && (int'(lpos) < HS_END);
  assign csync = hsync ^ vsync;
  assign blank = hsync | vsync | ~disp;
endmodule

module csync_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_en,
  input logic [2:0] cmd,
  input logic       hsync,
  input logic       vsync,
  input logic       csync,
  input logic       blank,
  input logic       hs_prev
);
  a_r8_hold_off_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> $stable({hsync, vsync, csync, blank}));

  a_r3_vsync_follows: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en |=> (vsync == ($past(cmd) == 3'b001)));

  a_r4_realign_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && cmd == 3'b010 && !hs_prev) |=> hsync);

  a_r5_display_no_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && cmd[2]) |=> (!vsync && (blank == hsync)));

  a_r7_blank_on_blank_code: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && !cmd[2]) |=> blank);
endmodule

bind csync_gen csync_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .cmd(cmd),
  .hsync(hsync), .vsync(vsync), .csync(csync), .blank(blank),
  .hs_prev(hs_prev)
);

// File: tb/csync_gen_tb.sv
module csync_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 114;
  localparam int HS_START = 4;
  localparam int HS_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, slot_en = 1'b0;
  logic [2:0] cmd = 3'b000;
  logic hsync, vsync, csync, blank;

  int total = 0, bad = 0, cycles = 0;
  int m_pos = 0;
  bit m_vs = 0, m_hsprev = 0, m_disp = 0, armed = 0, done = 0;
  bit e_hs;
  bit prev_hs = 0;
  int vs_rises = 0, vs_low_cs = 0, lh_rises = 0;
  bit in_long_hs = 0;

  csync_gen #(.LINE_SLOTS(LINE), .HS_START(HS_START), .HS_WIDTH(HS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .cmd(cmd),
    .hsync(hsync), .vsync(vsync), .csync(csync), .blank(blank));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", req, cycles, act, exp);
    end
  endtask

  // reference model, behavioural
  always @(posedge clk) begin
    cycles++;
    armed = 1;
    if (!rst_n) begin
      m_pos = 0; m_vs = 0; m_hsprev = 0; m_disp = 0;
    end else if (slot_en) begin
      if (cmd == 3'b010 && !m_hsprev) m_pos = HS_START;
      else m_pos = (m_pos + 1) % LINE;
      m_vs = (cmd == 3'b001);
      m_hsprev = (cmd == 3'b010);
      m_disp = cmd[2];
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      e_hs = (m_pos >= HS_START) && (m_pos < HS_START + HS_W);
      chk("R2/R4 hsync", hsync, e_hs);
      chk("R3/R5 vsync", vsync, m_vs);
      chk("R1 csync xor", csync, e_hs ^ m_vs);
      chk("R7 blank", blank, e_hs | m_vs | !m_disp);
      if (hsync && !prev_hs && vsync) vs_rises++;
      if (vsync && !csync) vs_low_cs++;
      if (hsync && !prev_hs && in_long_hs) lh_rises++;
      prev_hs = hsync;
    end
  end

  // one slot per 8 clocks; junk code on non-slot clocks (R8)
  task automatic slots(logic [2:0] code, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cmd = code; slot_en = 1'b1;
      @(negedge clk); slot_en = 1'b0; cmd = 3'b001;
      repeat (5) @(negedge clk);
      cmd = 3'b010;
      @(negedge clk);
    end
  endtask

  task automatic disp_line(bit inject);
    slots(3'b010, 9);
    slots(3'b000, 15);
    for (int k = 0; k < 90; k++) begin
      if (inject && k >= 40 && k < 43) slots(3'b010, 1);
      else slots(3'(3'b100 + (k % 4)), 1);
    end
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R6: reset state
    chk("R6 reset hsync", hsync, 1'b0);
    chk("R6 reset vsync", vsync, 1'b0);
    chk("R6 reset csync", csync, 1'b0);
    chk("R6 reset blank", blank, 1'b1);
    rst_n = 1'b1;
    // R2: free-running, blank codes only
    slots(3'b000, 2 * LINE);
    // R4/R5: display lines, one with mid-line hsync command
    disp_line(0); disp_line(1); disp_line(0);
    // vertical off-screen: long hsync, 3-line vsync, long hsync (R9)
    in_long_hs = 1;
    slots(3'b010, 2 * LINE);
    in_long_hs = 0;
    slots(3'b001, 3 * LINE);
    slots(3'b010, 2 * LINE);
    disp_line(0); disp_line(0);
    @(negedge clk);
    chk("R9 pulses during vsync == 3", vs_rises == 3, 1'b1);
    chk("R9 csync returns low in vsync", vs_low_cs > 0, 1'b1);
    chk("R4 pulses continue in long hsync", lh_rises >= 2, 1'b1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule